// File: doc/BRIEF.md
# SHA-256 Message Schedule Window

This block produces the sixty-four 32-bit schedule words that a SHA-256 compression core uses while it processes one 512-bit message block. It does not hold the whole schedule. It keeps only the sixteen most recent words in a shift window, and each word it derives becomes the current output straight away.

An init strobe loads all sixteen window registers at once from the block. The block is read as big-endian 32-bit words: bits 511:480 are word 0 and go into the bottom register, and bits 31:0 are word 15 and go into the top register. For the first sixteen rounds the window stays still, and a round counter selects which register drives the output. From round 16 on, each request for the next word does three things: it computes a new word from four window taps, shifts every register down by one place, and writes the new word into the top register. The top register drives the output. After round 63 the block ignores further requests until the next init.

Top module: `wsched_window`

## Requirements
- R1: A synchronous active-low reset clears all window registers and the round counter, so the cycle after reset the output reads 0.
- R2: An init strobe loads the window from the block in big-endian word order and restarts at round 0. The cycle after init, the output equals block bits 511:480.
- R3: During rounds 0 to 15, after k next strobes following an init the output equals block word k (bits 511-32k down to 480-32k), and the window does not shift.
- R4: From round 16 to round 63, each next strobe outputs a new word equal to sigma1(w[t-2]) + w[t-7] + sigma0(w[t-15]) + w[t-16] modulo 2^32, where sigma0 is ROTR7^ROTR18^SHR3 and sigma1 is ROTR17^ROTR19^SHR10. For the padded three-byte message "abc", word 17 is 0x000F0000.
- R5: Once round 63 is reached, further next strobes are ignored and the output stays at word 63.
- R6: In a cycle with neither strobe, the output and the round position do not change.
- R7: When init and next arrive in the same cycle, init wins. An init at any round, including mid-expansion, restarts the schedule from the new block's word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| initStb | input | 1 | Load a new block and restart at round 0 |
| nextStb | input | 1 | Advance to the next schedule word |
| blockIn | input | 512 | Message block, word 0 in bits 511:480 |
| wOut | output | 32 | Schedule word for the current round |

## Verification
The assertions check the control rules on every cycle: the reset value, that word 0 appears after an init, that the counter steps by one per accepted request and stays put at 63, that the output holds when there is no strobe, and that shifting happens only once the window has been read through. The arithmetic of the expansion and the big-endian word placement can only be shown by the scenarios, which compare all sixty-four words against a schedule the bench computes itself. The scenarios also cover a known vector, restarting partway through expansion, and init and next arriving together.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int WORD_W     = 32;
  localparam int WIN_DEPTH  = 16;
  localparam int NUM_ROUNDS = 64;
  localparam int SEL_W      = $clog2(WIN_DEPTH);
  localparam int CNT_W      = $clog2(NUM_ROUNDS);

  typedef struct packed {
    logic             load;
    logic             shift;
    logic [SEL_W-1:0] sel;
  } ctrlStb_t;

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int n);
    rotr = (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] smallSigma0(input logic [WORD_W-1:0] x);
    smallSigma0 = rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [WORD_W-1:0] smallSigma1(input logic [WORD_W-1:0] x);
    smallSigma1 = rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int ROUNDS = NUM_ROUNDS,
  parameter int DEPTH  = WIN_DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initStb,
  input  logic             nextStb,
  output ctrlStb_t         ctrlStb,
  output logic [CNT_W-1:0] roundIdx
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ROUNDS - 1);
  localparam logic [CNT_W-1:0] FILL_END = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);

  logic advance;

  // A request is accepted only when no init is pending and the schedule is not finished
  assign advance = nextStb && !initStb && (roundIdx != LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      roundIdx <= '0;
    end else if (initStb) begin
      roundIdx <= '0;
    end else if (advance) begin
      roundIdx <= roundIdx + 1'b1;
    end
  end

  always_comb begin
    ctrlStb.load  = initStb;
    ctrlStb.shift = advance && (roundIdx >= FILL_END);
    if (roundIdx < DEPTH_C) begin
      ctrlStb.sel = roundIdx[SEL_W-1:0];
    end else begin
      ctrlStb.sel = FILL_END[SEL_W-1:0];
    end
  end
endmodule

// File: rtl/wsched_dpath.sv
module wsched_dpath
  import wsched_pkg::*;
#(
  parameter int WIDTH = WORD_W,
  parameter int DEPTH = WIN_DEPTH
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [WIDTH*DEPTH-1:0] blockIn,
  input  ctrlStb_t               ctrlStb,
  output logic [WIDTH-1:0]       wOut
);
  localparam int TAP_S1 = DEPTH - 2;  // w[t-2]
  localparam int TAP_MD = DEPTH - 7;  // w[t-7]
  localparam int TAP_S0 = 1;          // w[t-15]
  localparam int TAP_LO = 0;          // w[t-16]

  logic [WIDTH-1:0] win [DEPTH];
  logic [WIDTH-1:0] newWord;

  assign newWord = smallSigma1(win[TAP_S1]) + win[TAP_MD] +
                   smallSigma0(win[TAP_S0]) + win[TAP_LO];

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic [WIDTH-1:0] shiftIn;
    if (i == DEPTH - 1) begin : gTop
      assign shiftIn = newWord;
    end else begin : gBody
      assign shiftIn = win[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        win[i] <= '0;
      end else if (ctrlStb.load) begin
        win[i] <= blockIn[WIDTH*(DEPTH-i)-1 -: WIDTH];
      end else if (ctrlStb.shift) begin
        win[i] <= shiftIn;
      end
    end
  end

  assign wOut = win[ctrlStb.sel];
endmodule

// File: rtl/wsched_window.sv
module wsched_window
  import wsched_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        initStb,
  input  logic                        nextStb,
  input  logic [WORD_W*WIN_DEPTH-1:0] blockIn,
  output logic [WORD_W-1:0]           wOut
);
  ctrlStb_t         ctrlStb;
  logic [CNT_W-1:0] roundIdx;

  wsched_ctrl #(.ROUNDS(NUM_ROUNDS), .DEPTH(WIN_DEPTH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .initStb  (initStb),
    .nextStb  (nextStb),
    .ctrlStb  (ctrlStb),
    .roundIdx (roundIdx)
  );

  wsched_dpath #(.WIDTH(WORD_W), .DEPTH(WIN_DEPTH)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .blockIn (blockIn),
    .ctrlStb (ctrlStb),
    .wOut    (wOut)
  );
endmodule

// File: rtl/wsched_checker.sv
module wsched_checker
  import wsched_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        initStb,
  input logic                        nextStb,
  input logic [WORD_W*WIN_DEPTH-1:0] blockIn,
  input logic [WORD_W-1:0]           wOut,
  input logic [CNT_W-1:0]            roundIdx,
  input ctrlStb_t                    ctrlStb
);
  localparam int BLK_W = WORD_W * WIN_DEPTH;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_ROUNDS - 1);
  localparam logic [CNT_W-1:0] FILL_END = CNT_W'(WIN_DEPTH - 1);

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |=> (wOut == '0 && roundIdx == '0)); // R1

  AST_INIT_WORD0: assert property (@(posedge clk) disable iff (!rstN)
    initStb |=> (wOut == $past(blockIn[BLK_W-1 -: WORD_W]) && roundIdx == '0)); // R2

  AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (nextStb && !initStb && roundIdx != LAST_IDX) |=> (roundIdx == $past(roundIdx) + 1'b1)); // R3

  AST_SHIFT_LATE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.shift |-> (roundIdx >= FILL_END && !initStb)); // R4

  AST_END_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (roundIdx == LAST_IDX && !initStb) |=> (roundIdx == LAST_IDX && $stable(wOut))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!initStb && !nextStb) |=> ($stable(wOut) && $stable(roundIdx))); // R6

  AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (initStb && nextStb) |=> (roundIdx == '0)); // R7
endmodule

bind wsched_window wsched_checker uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .initStb  (initStb),
  .nextStb  (nextStb),
  .blockIn  (blockIn),
  .wOut     (wOut),
  .roundIdx (roundIdx),
  .ctrlStb  (ctrlStb)
);

// File: tb/wsched_window_test.sv
module wsched_window_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         initStb = 1'b0;
  logic         nextStb = 1'b0;
  logic [511:0] blockIn = '0;
  logic [31:0]  wOut;

  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] ref_w[64];

  wsched_window uut (
    .clk(clk), .rstN(rstN), .initStb(initStb), .nextStb(nextStb),
    .blockIn(blockIn), .wOut(wOut)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  task automatic buildRef(input logic [511:0] blk);
    for (int t = 0; t < 64; t++) begin
      if (t < 16) ref_w[t] = blk[511 - 32*t -: 32];
      else ref_w[t] = (rr(ref_w[t-2], 17) ^ rr(ref_w[t-2], 19) ^ (ref_w[t-2] >> 10))
                    + ref_w[t-7]
                    + (rr(ref_w[t-15], 7) ^ rr(ref_w[t-15], 18) ^ (ref_w[t-15] >> 3))
                    + ref_w[t-16];
    end
  endtask

  // Driver: apply one cycle of stimulus, then queue what the output must show
  task automatic drive(input bit i, input bit n, input logic [511:0] blk,
                       input logic [31:0] expVal, input string tag);
    @(negedge clk);
    initStb = i; nextStb = n; blockIn = blk;
    @(posedge clk);
    #1;
    initStb = 1'b0; nextStb = 1'b0;
    expQ.push_back(expVal); tagQ.push_back(tag);
  endtask

  task automatic resetPulse(input string tag);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    rstN = 1'b1;
    expQ.push_back(32'h0); tagQ.push_back(tag);
  endtask

  // Monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [31:0] e;
      string tg;
      e = expQ.pop_front(); tg = tagQ.pop_front();
      checks++;
      if (wOut !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", tg, wOut, e);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [511:0] blkA, blkB, blkC;
    blkA = '0;
    blkA[511 -: 32] = 32'h61626380;
    blkA[31:0] = 32'h00000018;
    blkB = '0;
    blkC = '0;
    for (int i = 0; i < 16; i++) begin
      blkB[511 - 32*i -: 32] = (32'h9E3779B9 * (i + 1)) ^ 32'h5A5A0F0F;
      blkC[511 - 32*i -: 32] = 32'h01234567 + 32'h11111111 * i;
    end

    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    expQ.push_back(32'h0); tagQ.push_back("R1 reset");

    // Known vector, full 64 words
    buildRef(blkA);
    drive(1, 0, blkA, ref_w[0], "R2 init word0");
    for (int k = 1; k < 64; k++) begin
      if (k == 17) drive(0, 1, blkA, 32'h000F0000, "R4 known word17");
      else if (k < 16) drive(0, 1, blkA, ref_w[k], "R3 loaded word");
      else drive(0, 1, blkA, ref_w[k], "R4 expanded word");
    end
    for (int k = 0; k < 3; k++) drive(0, 1, blkA, ref_w[63], "R5 next after end");
    for (int k = 0; k < 2; k++) drive(0, 0, blkA, ref_w[63], "R6 idle at end");

    // Second block with an idle gap during the loaded phase
    buildRef(blkB);
    drive(1, 0, blkB, ref_w[0], "R2 init block B");
    for (int k = 1; k <= 5; k++) drive(0, 1, blkB, ref_w[k], "R3 block B word");
    drive(0, 0, blkB, ref_w[5], "R6 idle mid fill");
    for (int k = 6; k <= 20; k++) begin
      if (k < 16) drive(0, 1, blkB, ref_w[k], "R3 block B word");
      else drive(0, 1, blkB, ref_w[k], "R4 block B word");
    end
    drive(0, 0, blkB, ref_w[20], "R6 idle mid expand");

    // Init and next together during expansion
    buildRef(blkC);
    drive(1, 1, blkC, ref_w[0], "R7 init beats next");
    for (int k = 1; k <= 17; k++) begin
      if (k < 16) drive(0, 1, blkC, ref_w[k], "R7 restart word");
      else drive(0, 1, blkC, ref_w[k], "R7 restart expand");
    end

    resetPulse("R1 reset mid run");
    drive(0, 0, blkC, 32'h0, "R1 hold after reset");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule